// File: doc/BRIEF.md
# Rounding fractional multiply unit

This execution unit takes one 32-bit instruction word and two 32-bit source values. It performs a signed fractional multiply of two half-words with rounding. The instruction chooses whether both operands come from the lower half-words or both come from the upper half-words. It also chooses whether the product is doubled, which gives left-justified fractional alignment.

The 32-bit intermediate is formed from the product and a rounding constant of half a result LSB. The unit returns the upper half of that intermediate in the upper half of the destination value. The lower half of the destination is always zero. Exactly one operand pair overflows the doubled form: most-negative times most-negative. That case is forced to the largest positive intermediate.

Alongside the data, the unit reports the following:
- the destination register index taken from the instruction;
- an overflow flag value, which is always cleared;
- an advanced-overflow flag derived from the top two intermediate bits;
- the updated sticky advanced-overflow bit;
- a strobe that says whether these flag writes apply;
- an illegal-encoding indication.

All outputs are registered. They appear one clock after a valid input.

Top module: `frac_mulr_unit`

## Requirements
- R1: Secondary opcode field instr[27:18] equal to 0x006 selects the upper half-words src_a[31:16] and src_b[31:16] as operands. A value of 0x007 selects the lower half-words src_a[15:0] and src_b[15:0].
- R2: For a legal instruction, result[31:16] equals bits [31:16] of P + 0x8000 taken modulo 2^32, and result[15:0] is zero. P is the signed 16x16 product shifted left by the shift field instr[17:16].
- R3: When both selected half-words are 0x8000 and the shift field is 1, the intermediate is 0x7FFFFFFF, so result is 0x7FFF0000.
- R4: An instruction is legal when instr[7:0] is 0x93, the secondary opcode is 0x006 or 0x007, and the shift field is 0 or 1. dst_idx always carries instr[31:28].
- R5: For a legal instruction, flag_we is 1 and ovf_out is 0. ovf_out is 0 at all times.
- R6: For a legal instruction, adv_ovf equals bit 31 XOR bit 30 of the intermediate.
- R7: For a legal instruction, sticky_av_out equals sticky_av_in OR adv_ovf. The operation can set the sticky bit but never clear it.
- R8: When both opcodes match but the shift field is 2 or 3, the unit does the following:
  - illegal is 1;
  - result is 0;
  - flag_we and adv_ovf are 0;
  - sticky_av_out equals sticky_av_in.
- R9: When the primary or secondary opcode does not match, illegal is 1 and the outputs behave as in R8.
- R10: out_valid is 1 exactly in the cycle after a cycle with in_valid high. After a cycle with in_valid low, out_valid is 0 and all data outputs hold their values.
- R11: A synchronous active-high reset clears out_valid, result, dst_idx, flag_we, adv_ovf, sticky_av_out and illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operands present this cycle |
| instr | input | 32 | Instruction word |
| src_a | input | 32 | First source register value |
| src_b | input | 32 | Second source register value |
| sticky_av_in | input | 1 | Current sticky advanced-overflow bit |
| out_valid | output | 1 | Result registered from the previous cycle's input |
| dst_idx | output | 4 | Destination register index |
| result | output | 32 | Destination value; lower half zero |
| flag_we | output | 1 | Flag updates below apply |
| ovf_out | output | 1 | Overflow flag value (cleared) |
| adv_ovf | output | 1 | Advanced-overflow flag value |
| sticky_av_out | output | 1 | Updated sticky advanced-overflow bit |
| illegal | output | 1 | Unrecognised or undefined encoding |

## Verification
The bench builds the unit with its default half-word width of 16. That width places the 0x8000 by 0x8000 saturation corner within reach, along with both signs of the 0x7FFF products and the rounding carry into bit 16. Directed cases exercise saturation in each half-word form, with a mismatching opposite half in each case so that selection errors show up. Further directed cases cover n of 0 against n of 1 on the same operands, every shift field of 2 or 3, and foreign primary and secondary opcodes. Random traffic then mixes those corner operands with idle gaps and both sticky input levels.

// File: rtl/frac_mulr_pkg.sv
package frac_mulr_pkg;
  localparam int INSTR_W   = 32;
  localparam int REG_IDX_W = 4;
  localparam int SHAMT_W   = 2;

  localparam logic [7:0] OPC_MAJOR = 8'h93;
  localparam logic [9:0] OPC_LOWER = 10'h007;
  localparam logic [9:0] OPC_UPPER = 10'h006;

  typedef struct packed {
    logic [REG_IDX_W-1:0] dst;
    logic [SHAMT_W-1:0]   shamt;
    logic                 upper;
    logic                 opc_ok;
    logic                 shamt_ok;
  } mulr_dec_t;
endpackage

// File: rtl/frac_mulr_decode.sv
module frac_mulr_decode
  import frac_mulr_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output mulr_dec_t          dec,
  output logic               legal
);
  logic [7:0] major_f;
  logic [9:0] minor_f;
  logic       unused_src_idx;

  assign major_f        = instr[7:0];
  assign minor_f        = instr[27:18];
  assign unused_src_idx = ^instr[15:8];

  always_comb begin
    dec.dst      = instr[31:28];
    dec.shamt    = instr[17:16];
    dec.upper    = (minor_f == OPC_UPPER);
    dec.opc_ok   = (major_f == OPC_MAJOR) &&
                   ((minor_f == OPC_UPPER) || (minor_f == OPC_LOWER));
    dec.shamt_ok = (instr[17:16] == 2'd0) || (instr[17:16] == 2'd1);
  end

  assign legal = dec.opc_ok && dec.shamt_ok;
endmodule

// File: rtl/frac_mulr_dp.sv
module frac_mulr_dp #(
  parameter int HW = 16
) (
  input  logic [2*HW-1:0] src_a,
  input  logic [2*HW-1:0] src_b,
  input  logic            upper,
  input  logic            shift_one,
  output logic [2*HW-1:0] inter,
  output logic            sat_hit,
  output logic            adv
);
  localparam int W = 2 * HW;
  localparam logic [HW-1:0] HALF_MIN = {1'b1, {(HW-1){1'b0}}};
  localparam logic [W-1:0]  RND      = {{HW{1'b0}}, 1'b1, {(HW-1){1'b0}}};
  localparam logic [W-1:0]  SAT      = {1'b0, {(W-1){1'b1}}};

  function automatic logic [HW-1:0] pick_half(logic [W-1:0] v, logic hi);
    return hi ? v[W-1:HW] : v[HW-1:0];
  endfunction

  function automatic logic [W-1:0] frac_mul(logic [HW-1:0] x, logic [HW-1:0] y,
                                             logic dbl);
    logic signed [W-1:0] p;
    p = $signed(x) * $signed(y);
    return dbl ? {p[W-2:0], 1'b0} : p;
  endfunction

  logic [HW-1:0] op_x, op_y;
  logic [W-1:0]  prod_sh;

  assign op_x    = pick_half(src_a, upper);
  assign op_y    = pick_half(src_b, upper);
  assign prod_sh = frac_mul(op_x, op_y, shift_one);
  assign sat_hit = (op_x == HALF_MIN) && (op_y == HALF_MIN) && shift_one;
  assign inter   = sat_hit ? SAT : (prod_sh + RND);
  assign adv     = inter[W-1] ^ inter[W-2];
endmodule

// File: rtl/frac_mulr_unit.sv
module frac_mulr_unit
  import frac_mulr_pkg::*;
#(
  parameter int HW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [INSTR_W-1:0]   instr,
  input  logic [2*HW-1:0]      src_a,
  input  logic [2*HW-1:0]      src_b,
  input  logic                 sticky_av_in,
  output logic                 out_valid,
  output logic [REG_IDX_W-1:0] dst_idx,
  output logic [2*HW-1:0]      result,
  output logic                 flag_we,
  output logic                 ovf_out,
  output logic                 adv_ovf,
  output logic                 sticky_av_out,
  output logic                 illegal
);
  localparam int W = 2 * HW;
  localparam logic [W-1:0] SAT_RES = {1'b0, {(HW-1){1'b1}}, {HW{1'b0}}};

  mulr_dec_t     dec;
  logic          legal;
  logic [W-1:0]  inter;
  logic          sat_hit;
  logic          adv;

  frac_mulr_decode u_dec (
    .instr (instr),
    .dec   (dec),
    .legal (legal)
  );

  frac_mulr_dp #(.HW(HW)) u_dp (
    .src_a     (src_a),
    .src_b     (src_b),
    .upper     (dec.upper),
    .shift_one (dec.shamt == 2'd1),
    .inter     (inter),
    .sat_hit   (sat_hit),
    .adv       (adv)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      dst_idx       <= '0;
      result        <= '0;
      flag_we       <= 1'b0;
      adv_ovf       <= 1'b0;
      sticky_av_out <= 1'b0;
      illegal       <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        dst_idx       <= dec.dst;
        result        <= legal ? {inter[W-1:HW], {HW{1'b0}}} : '0;
        flag_we       <= legal;
        adv_ovf       <= legal & adv;
        sticky_av_out <= sticky_av_in | (legal & adv);
        illegal       <= ~legal;
      end
    end
  end

  assign ovf_out = 1'b0;

  // R10
  out_valid_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid && $stable(result) && $stable(dst_idx));

  // R2
  low_half_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> result[HW-1:0] == '0);

  // R8 R9
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && illegal |-> result == '0 && !flag_we && !adv_ovf);

  // R7
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && flag_we |-> sticky_av_out == (adv_ovf | $past(sticky_av_in)));

  // R3
  sat_path_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && legal && sat_hit |=> result == SAT_RES && adv_ovf);

  // R4
  dst_field_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> dst_idx == $past(instr[31:28]));
endmodule

// File: tb/frac_mulr_unit_tb.sv
`timescale 1ns/1ps
module frac_mulr_unit_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] instr, src_a, src_b;
  logic        sticky_av_in;
  logic        out_valid, flag_we, ovf_out, adv_ovf, sticky_av_out, illegal;
  logic [3:0]  dst_idx;
  logic [31:0] result;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // model state
  logic        e_valid, e_we, e_adv, e_sticky, e_ill;
  logic [3:0]  e_dst;
  logic [31:0] e_res;
  string       e_rtag, e_itag;

  always #2.5 clk = ~clk;

  frac_mulr_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .src_a(src_a), .src_b(src_b), .sticky_av_in(sticky_av_in),
    .out_valid(out_valid), .dst_idx(dst_idx), .result(result),
    .flag_we(flag_we), .ovf_out(ovf_out), .adv_ovf(adv_ovf),
    .sticky_av_out(sticky_av_out), .illegal(illegal)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_instr(logic [7:0] op1, logic [9:0] op2,
                                           int n, logic [3:0] d);
    logic [31:0] w;
    w = {d, op2, 2'(n), 4'h3, 4'h5, op1};
    return w;
  endfunction

  // behavioural reference: integers, no structure shared with the design
  task automatic model(logic v, logic [31:0] ins, logic [31:0] a, logic [31:0] b,
                       logic s);
    int  n;
    bit  op_ok, hi, sat;
    longint x, y, p;
    logic [31:0] m;
    e_valid = v;
    if (!v) return;
    n     = int'(ins[17:16]);
    hi    = (ins[27:18] == 10'h006);
    op_ok = (ins[7:0] == 8'h93) && (ins[27:18] == 10'h006 || ins[27:18] == 10'h007);
    x = hi ? longint'($signed(a[31:16])) : longint'($signed(a[15:0]));
    y = hi ? longint'($signed(b[31:16])) : longint'($signed(b[15:0]));
    sat = (x == -32768) && (y == -32768) && (n == 1);
    p = x * y * ((n == 1) ? 2 : 1) + 32768;
    m = sat ? 32'h7FFF_FFFF : p[31:0];
    e_dst = ins[31:28];
    if (op_ok && n < 2) begin
      e_res = {m[31:16], 16'h0000};
      e_we = 1; e_adv = m[31] ^ m[30]; e_sticky = s | e_adv; e_ill = 0;
      e_rtag = sat ? "R3" : (hi ? "R1" : "R2");
      e_itag = "R4";
    end else begin
      e_res = 0; e_we = 0; e_adv = 0; e_sticky = s; e_ill = 1;
      e_itag = op_ok ? "R8" : "R9";
      e_rtag = e_itag;
    end
  endtask

  task automatic compare();
    chk("R10", "out_valid", 32'(out_valid), 32'(e_valid));
    chk("R4", "dst_idx", 32'(dst_idx), 32'(e_dst));
    chk(e_rtag, "result", result, e_res);
    chk(e_ill ? e_itag : "R5", "flag_we", 32'(flag_we), 32'(e_we));
    chk("R5", "ovf_out", 32'(ovf_out), 32'd0);
    chk(e_ill ? e_itag : "R6", "adv_ovf", 32'(adv_ovf), 32'(e_adv));
    chk(e_ill ? e_itag : "R7", "sticky_av_out", 32'(sticky_av_out), 32'(e_sticky));
    chk(e_itag, "illegal", 32'(illegal), 32'(e_ill));
  endtask

  task automatic step(logic v, logic [31:0] ins, logic [31:0] a, logic [31:0] b,
                      logic s);
    @(negedge clk);
    compare();
    in_valid = v; instr = ins; src_a = a; src_b = b; sticky_av_in = s;
    model(v, ins, a, b, s);
  endtask

  function automatic logic [15:0] pick_op();
    int k;
    k = $urandom_range(0, 7);
    case (k)
      0: return 16'h8000;
      1: return 16'h7FFF;
      2: return 16'hFFFF;
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    rst = 1; in_valid = 0; instr = 0; src_a = 0; src_b = 0; sticky_av_in = 0;
    e_valid = 0; e_dst = 0; e_res = 0; e_we = 0; e_adv = 0; e_sticky = 0; e_ill = 0;
    e_rtag = "R11"; e_itag = "R11";
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", "out_valid", 32'(out_valid), 0);
    chk("R11", "result", result, 0);
    chk("R11", "flag_we", 32'(flag_we), 0);
    chk("R11", "illegal", 32'(illegal), 0);
    chk("R11", "sticky_av_out", 32'(sticky_av_out), 0);
    rst = 0;
    // R3 saturation in lower form, upper halves differ
    step(1, mk_instr(8'h93, 10'h007, 1, 4'd2), 32'h1234_8000, 32'h0001_8000, 0);
    // R3 saturation in upper form, lower halves differ
    step(1, mk_instr(8'h93, 10'h006, 1, 4'd3), 32'h8000_0001, 32'h8000_7FFF, 1);
    // R2 same operands with n=0
    step(1, mk_instr(8'h93, 10'h007, 0, 4'd4), 32'h0000_8000, 32'h0000_8000, 0);
    // R1 upper selection with lower-half saturation operands
    step(1, mk_instr(8'h93, 10'h006, 1, 4'd5), 32'h7FFF_8000, 32'h7FFF_8000, 0);
    // R10 idle gap holds data
    step(0, 32'h0, 32'h0, 32'h0, 0);
    step(0, 32'hFFFF_FFFF, 32'h1, 32'h1, 1);
    // R6 negative product with AV set; R7 sticky stays set
    step(1, mk_instr(8'h93, 10'h007, 1, 4'd6), 32'h0000_8000, 32'h0000_7FFF, 1);
    // R2 small values rounding to zero; R7 sticky remains 1 with AV 0
    step(1, mk_instr(8'h93, 10'h007, 1, 4'd7), 32'h0000_0001, 32'h0000_0001, 1);
    // R2 rounding carry into bit 16
    step(1, mk_instr(8'h93, 10'h007, 0, 4'd8), 32'h0000_0100, 32'h0000_0080, 0);
    // R8 shift field 2 and 3
    step(1, mk_instr(8'h93, 10'h007, 2, 4'd9), 32'h0000_8000, 32'h0000_8000, 1);
    step(1, mk_instr(8'h93, 10'h006, 3, 4'd10), 32'h7FFF_0000, 32'h7FFF_0000, 0);
    // R9 foreign primary and secondary opcodes
    step(1, mk_instr(8'h92, 10'h007, 1, 4'd11), 32'h0000_4000, 32'h0000_4000, 1);
    step(1, mk_instr(8'h93, 10'h005, 0, 4'd12), 32'h0000_4000, 32'h0000_4000, 0);
    step(1, mk_instr(8'h93, 10'h047, 0, 4'd13), 32'h0000_4000, 32'h0000_4000, 0);
    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [7:0] o1;
      logic [9:0] o2;
      int n;
      o1 = ($urandom_range(0, 7) == 0) ? 8'($urandom) : 8'h93;
      case ($urandom_range(0, 5))
        0: o2 = 10'($urandom);
        1, 2: o2 = 10'h006;
        default: o2 = 10'h007;
      endcase
      n = ($urandom_range(0, 5) == 0) ? $urandom_range(2, 3) : $urandom_range(0, 1);
      step($urandom_range(0, 3) != 0, mk_instr(o1, o2, n, 4'($urandom)),
           {pick_op(), pick_op()}, {pick_op(), pick_op()}, 1'($urandom));
    end
    step(0, 32'h0, 32'h0, 32'h0, 0);
    @(negedge clk);
    compare();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule